// File: doc/BRIEF.md
# Triggered Delayed Pulse-Train Channel

One output channel of a trigger-delay unit. It receives trigger events, each with its own timestamp, from a shared input stage. For each trigger it accepts, it computes a start time: the trigger timestamp plus a programmed delay. It compares that start time against a free-running time counter that all channels share. When the counter reaches the start time, the channel emits a train of pulses. Width, spacing and pulse count are programmable. The train may instead be a continuous square wave that runs until the channel is disabled. All timing is in whole clock cycles, one cycle being 4 ns at the intended rate. Fine sub-cycle placement happens outside this block.

A channel that is busy with a pending or running train discards further triggers. For example, with a trigger every 250 cycles and a delay of 1250 cycles, only every sixth trigger produces a train. The settings are captured at the moment a trigger is accepted, so a write during a train affects only the next train. Clearing the enable input cancels any activity and parks the output low.

Top module: `delay_train_channel`

## Requirements
- R1: During and immediately after reset, `pulseOut` and `busy` are both 0.
- R2: A trigger is accepted when `trigValid` is high at a clock edge while `busy` is 0 and `cfgEnable` is 1. The start time is `trigTime + cfgDelay`. The first pulse rises at the first clock edge at which the sampled `nowTime` is greater than or equal to the start time. With `nowTime` advancing by one per cycle, the output is first seen high in the cycle where `nowTime` equals start + 1.
- R3: Each pulse stays high for `cfgWidth` cycles. A width of 0 is treated as 1.
- R4: Rising edges are spaced by `cfgPeriod` cycles. If `cfgPeriod` is not greater than the effective width, the low gap is forced to one cycle, so the spacing becomes width + 1.
- R5: When `cfgContinuous` is 0, a train has `cfgCount + 1` pulses. A 16-bit count of 0 gives 1 pulse and all ones gives 65536 pulses. `busy` falls on the same edge as the falling edge of the last pulse.
- R6: When `cfgContinuous` is 1, `cfgCount` is ignored and pulses repeat until `cfgEnable` is cleared.
- R7: A trigger that arrives while `busy` is 1 is discarded and does not alter the running train.
- R8: Changes to `cfgDelay`, `cfgWidth`, `cfgPeriod`, `cfgCount` or `cfgContinuous` while `busy` is 1 do not affect the running train.
- R9: When `cfgEnable` is 0 at a clock edge, `pulseOut` and `busy` are 0 from that edge on. Triggers are ignored while `cfgEnable` is 0.
- R10: If the start time is already in the past when the trigger is accepted, the first pulse rises on the next clock edge. The output is first seen high two cycles after the trigger was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigValid | input | 1 | Trigger event strobe |
| trigTime | input | TIME_W (48) | Timestamp of the trigger event |
| nowTime | input | TIME_W (48) | Shared time counter, in cycles |
| cfgEnable | input | 1 | Channel enable; 0 cancels activity |
| cfgContinuous | input | 1 | 1 selects an endless square wave |
| cfgDelay | input | DELAY_W (36) | Trigger-to-start delay in cycles |
| cfgWidth | input | WIDTH_W (32) | High time per pulse in cycles |
| cfgPeriod | input | PERIOD_W (32) | Rising-edge spacing in cycles |
| cfgCount | input | COUNT_W (16) | Pulse count minus one |
| pulseOut | output | 1 | Registered pulse output |
| busy | output | 1 | A train is pending or running |

## Verification
The checks assume that `nowTime` advances by one every cycle. They also assume that a start time never lies more than half the counter range from `nowTime`, because the start comparison is taken from the sign of a wrapped difference.

The bench drives the time counter as a plain incrementing register and launches each trigger with a timestamp a few cycles in the past. Delays, widths and periods are kept small, so every start time stays close to the counter.

Random triggers and setting changes are injected only in cycles where the model says the channel is busy. Every injection therefore falls inside the window where it must be discarded.

// File: rtl/delay_train_pkg.sv
package delay_train_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HIGH,
    ST_LOW
  } chanState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;       // capture settings and compute start time
    logic startHigh;  // load phase counter with width - 1
    logic startLow;   // load phase counter with gap - 1
    logic advance;    // move to next pulse of the train
    logic outSet;     // drive output high
    logic outClr;     // drive output low
  } chanStrobe_t;

endpackage

// File: rtl/delay_train_datapath.sv
module delay_train_datapath
  import delay_train_pkg::*;
#(
  parameter int TIME_W   = 48,
  parameter int DELAY_W  = 36,
  parameter int WIDTH_W  = 32,
  parameter int PERIOD_W = 32,
  parameter int COUNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  chanStrobe_t         stb,
  input  logic [TIME_W-1:0]   trigTime,
  input  logic [TIME_W-1:0]   nowTime,
  input  logic                cfgContinuous,
  input  logic [DELAY_W-1:0]  cfgDelay,
  input  logic [WIDTH_W-1:0]  cfgWidth,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [COUNT_W-1:0]  cfgCount,
  output logic                startReached,
  output logic                phaseDone,
  output logic                lastPulse,
  output logic                contMode,
  output logic                pulseOut
);

  localparam int PH_W = (WIDTH_W > PERIOD_W) ? WIDTH_W : PERIOD_W;

  logic [TIME_W-1:0]  startTime;
  logic [PH_W-1:0]    widthM1, gapM1, phaseCnt;
  logic [COUNT_W-1:0] countReg, pulseCnt;
  logic               contReg, outReg;

  // Effective width and gap derived from the live settings at load time
  logic [PH_W-1:0] widthExt, periodExt, widthEff, gapEff;
  always_comb begin
    widthExt  = PH_W'(cfgWidth);
    periodExt = PH_W'(cfgPeriod);
    widthEff  = (widthExt == '0) ? PH_W'(1) : widthExt;
    gapEff    = (periodExt > widthEff) ? (periodExt - widthEff) : PH_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startTime <= '0;
      widthM1   <= '0;
      gapM1     <= '0;
      countReg  <= '0;
      contReg   <= 1'b0;
    end else if (stb.load) begin
      startTime <= trigTime + TIME_W'(cfgDelay);
      widthM1   <= widthEff - PH_W'(1);
      gapM1     <= gapEff - PH_W'(1);
      countReg  <= cfgCount;
      contReg   <= cfgContinuous;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (stb.startHigh) begin
      phaseCnt <= widthM1;
    end else if (stb.startLow) begin
      phaseCnt <= gapM1;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (stb.load) begin
      pulseCnt <= '0;
    end else if (stb.advance) begin
      pulseCnt <= pulseCnt + COUNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= 1'b0;
    end else if (stb.outClr) begin
      outReg <= 1'b0;
    end else if (stb.outSet) begin
      outReg <= 1'b1;
    end
  end

  // Wrap-safe "now >= start": sign of the difference
  logic [TIME_W-1:0] timeDiff;
  assign timeDiff     = nowTime - startTime;
  assign startReached = ~timeDiff[TIME_W-1];
  assign phaseDone    = (phaseCnt == '0);
  assign lastPulse    = (pulseCnt == countReg);
  assign contMode     = contReg;
  assign pulseOut     = outReg;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(startTime) && $stable(countReg) && $stable(widthM1)); // R8
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReg) |-> $past(stb.outSet)); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !contReg |-> pulseCnt <= countReg); // R5

endmodule

// File: rtl/delay_train_control.sv
module delay_train_control
  import delay_train_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigValid,
  input  logic        cfgEnable,
  input  logic        startReached,
  input  logic        phaseDone,
  input  logic        lastPulse,
  input  logic        contMode,
  output chanStrobe_t stb,
  output logic        busy
);

  chanState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (!cfgEnable) begin
      stb.outClr = 1'b1;
      stateNext  = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (trigValid) begin
          stb.load  = 1'b1;
          stateNext = ST_WAIT;
        end
        ST_WAIT: if (startReached) begin
          stb.startHigh = 1'b1;
          stb.outSet    = 1'b1;
          stateNext     = ST_HIGH;
        end
        ST_HIGH: if (phaseDone) begin
          stb.outClr = 1'b1;
          if (lastPulse && !contMode) begin
            stateNext = ST_IDLE;
          end else begin
            stb.startLow = 1'b1;
            stateNext    = ST_LOW;
          end
        end
        ST_LOW: if (phaseDone) begin
          stb.startHigh = 1'b1;
          stb.outSet    = 1'b1;
          stb.advance   = 1'b1;
          stateNext     = ST_HIGH;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> state == ST_IDLE); // R9
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !startReached && cfgEnable) |=> state == ST_WAIT); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && phaseDone && lastPulse && !contMode && cfgEnable) |=> state == ST_IDLE); // R5
  AST_CONT_NO_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && contMode && cfgEnable) |=> state != ST_IDLE); // R6
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && trigValid) |-> !stb.load); // R7

endmodule

// File: rtl/delay_train_channel.sv
module delay_train_channel
  import delay_train_pkg::*;
#(
  parameter int TIME_W   = 48,
  parameter int DELAY_W  = 36,
  parameter int WIDTH_W  = 32,
  parameter int PERIOD_W = 32,
  parameter int COUNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigValid,
  input  logic [TIME_W-1:0]   trigTime,
  input  logic [TIME_W-1:0]   nowTime,
  input  logic                cfgEnable,
  input  logic                cfgContinuous,
  input  logic [DELAY_W-1:0]  cfgDelay,
  input  logic [WIDTH_W-1:0]  cfgWidth,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [COUNT_W-1:0]  cfgCount,
  output logic                pulseOut,
  output logic                busy
);

  chanStrobe_t stb;
  logic startReached, phaseDone, lastPulse, contMode;

  delay_train_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .trigValid    (trigValid),
    .cfgEnable    (cfgEnable),
    .startReached (startReached),
    .phaseDone    (phaseDone),
    .lastPulse    (lastPulse),
    .contMode     (contMode),
    .stb          (stb),
    .busy         (busy)
  );

  delay_train_datapath #(
    .TIME_W   (TIME_W),
    .DELAY_W  (DELAY_W),
    .WIDTH_W  (WIDTH_W),
    .PERIOD_W (PERIOD_W),
    .COUNT_W  (COUNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .trigTime      (trigTime),
    .nowTime       (nowTime),
    .cfgContinuous (cfgContinuous),
    .cfgDelay      (cfgDelay),
    .cfgWidth      (cfgWidth),
    .cfgPeriod     (cfgPeriod),
    .cfgCount      (cfgCount),
    .startReached  (startReached),
    .phaseDone     (phaseDone),
    .lastPulse     (lastPulse),
    .contMode      (contMode),
    .pulseOut      (pulseOut)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pulseOut); // R1

endmodule

// File: tb/tb_delay_train_channel.sv
module tb_delay_train_channel;
  localparam int TIME_W = 48, DELAY_W = 36, WIDTH_W = 32, PERIOD_W = 32, COUNT_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, trigValid = 1'b0, cfgEnable = 1'b0, cfgContinuous = 1'b0;
  logic [TIME_W-1:0]   trigTime = '0, nowTime = '0;
  logic [DELAY_W-1:0]  cfgDelay = '0;
  logic [WIDTH_W-1:0]  cfgWidth = '0;
  logic [PERIOD_W-1:0] cfgPeriod = '0;
  logic [COUNT_W-1:0]  cfgCount = '0;
  logic pulseOut, busy;

  int compared = 0, mismatched = 0;

  // Model of the expected train
  longint mT0, mFirst, mW, mP, mN, mStop;
  bit mActive = 1'b0, mCont = 1'b0;

  delay_train_channel dut (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigTime(trigTime), .nowTime(nowTime),
    .cfgEnable(cfgEnable), .cfgContinuous(cfgContinuous), .cfgDelay(cfgDelay),
    .cfgWidth(cfgWidth), .cfgPeriod(cfgPeriod), .cfgCount(cfgCount),
    .pulseOut(pulseOut), .busy(busy)
  );

  always @(posedge clk) begin
    if (!rstN) nowTime <= 48'd1000;
    else       nowTime <= nowTime + 48'd1;
  end

  function automatic bit expPulse(longint t);
    longint rel;
    if (!mActive || t >= mStop) return 1'b0;
    rel = t - mFirst;
    if (rel < 0) return 1'b0;
    if (!mCont && rel >= (mN - 1) * mP + mW) return 1'b0;
    return (rel % mP) < mW;
  endfunction

  function automatic bit expBusy(longint t);
    if (!mActive || t >= mStop || t < mT0 + 1) return 1'b0;
    return mCont || (t < mFirst + (mN - 1) * mP + mW);
  endfunction

  function automatic int spanCycles();
    return int'(mFirst + (mN - 1) * mP + mW - mT0 + 3);
  endfunction

  task automatic check(input logic act, input bit exp, input string tag, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at time %0d", tag, what, act, exp, nowTime);
    end
  endtask

  task automatic launch(input longint delay, input longint w, input longint p,
                        input longint cnt, input bit cont, input longint lag);
    longint start;
    @(negedge clk);
    cfgDelay      = DELAY_W'(delay);
    cfgWidth      = WIDTH_W'(w);
    cfgPeriod     = PERIOD_W'(p);
    cfgCount      = COUNT_W'(cnt);
    cfgContinuous = cont;
    trigTime      = nowTime - TIME_W'(lag);
    trigValid     = 1'b1;
    mT0    = longint'(nowTime);
    start  = longint'(trigTime) + delay;
    mW     = (w == 0) ? 1 : w;
    mP     = (p > mW) ? p : mW + 1;
    mN     = cnt + 1;
    mCont  = cont;
    mStop  = 64'sh7fff_ffff_ffff_ffff;
    mActive = 1'b1;
    mFirst = ((start > mT0 + 1) ? start : mT0 + 1) + 1;
  endtask

  task automatic watch(input int cycles, input string tag, input bit noise);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      trigValid = 1'b0;
      check(pulseOut, expPulse(longint'(nowTime)), tag, "pulseOut");
      check(busy, expBusy(longint'(nowTime)), tag, "busy");
      if (noise && expBusy(longint'(nowTime))) begin
        if ($urandom % 3 == 0) begin  // R7: trigger while busy
          trigValid = 1'b1;
          trigTime  = nowTime;
        end
        if ($urandom % 4 == 0) begin  // R8: settings change while busy
          cfgDelay      = DELAY_W'($urandom % 50);
          cfgWidth      = WIDTH_W'($urandom % 9);
          cfgPeriod     = PERIOD_W'($urandom % 12);
          cfgCount      = COUNT_W'($urandom % 7);
          cfgContinuous = 1'($urandom % 2);
        end
      end
    end
  endtask

  task automatic disableNow(input string tag);
    @(negedge clk);
    trigValid = 1'b0;
    check(pulseOut, expPulse(longint'(nowTime)), tag, "pulseOut");
    check(busy, expBusy(longint'(nowTime)), tag, "busy");
    cfgEnable = 1'b0;
    mStop = longint'(nowTime) + 1;
  endtask

  initial begin
    void'($urandom(32'd24681357));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(pulseOut, 1'b0, "R1", "pulseOut");
      check(busy, 1'b0, "R1", "busy");
    end
    rstN = 1'b1;
    cfgEnable = 1'b1;
    @(negedge clk);
    check(pulseOut, 1'b0, "R1", "pulseOut");
    check(busy, 1'b0, "R1", "busy");

    // R2 start time, with R3 width, R4 period, R5 count
    launch(20, 3, 7, 2, 1'b0, 2);
    watch(spanCycles(), "R2", 1'b0);
    // R4: period not above width, gap forced to one cycle
    launch(10, 5, 4, 1, 1'b0, 1);
    watch(spanCycles(), "R4", 1'b0);
    // R3: zero width treated as one
    launch(8, 0, 0, 2, 1'b0, 1);
    watch(spanCycles(), "R3", 1'b0);
    // R10: start time already passed
    launch(0, 2, 4, 0, 1'b0, 6);
    watch(spanCycles(), "R10", 1'b0);
    // R5: long finite train
    launch(12, 1, 3, 300, 1'b0, 2);
    watch(spanCycles(), "R5", 1'b0);

    // R6: continuous wave, then R9 disable
    launch(15, 2, 5, 0, 1'b1, 2);
    watch(60, "R6", 1'b0);
    disableNow("R9");
    watch(4, "R9", 1'b0);
    // R9: trigger while disabled is ignored
    @(negedge clk);
    trigValid = 1'b1;
    trigTime  = nowTime;
    cfgDelay  = '0;
    watch(4, "R9", 1'b0);
    @(negedge clk);
    cfgEnable = 1'b1;
    watch(3, "R9", 1'b0);

    // R9: disable in the middle of a finite train
    launch(5, 4, 6, 10, 1'b0, 1);
    watch(20, "R9", 1'b0);
    disableNow("R9");
    watch(4, "R9", 1'b0);
    @(negedge clk);
    cfgEnable = 1'b1;
    mActive = 1'b0;
    watch(3, "R9", 1'b0);

    // R7 and R8: random trains with triggers and writes injected while busy
    for (int k = 0; k < 25; k++) begin
      launch(longint'($urandom % 60), longint'($urandom % 8), longint'($urandom % 12),
             longint'($urandom % 5), 1'b0, longint'($urandom % 4));
      watch(spanCycles(), "R7/R8", 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule